// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts visible video lines and raises a level interrupt toward the CPU after a programmed number of them. The CPU programs it through four write-decoded registers: a direct counter load, a reload latch, a disable/acknowledge register and an enable register. The video side supplies a single-cycle pulse per line, the current line number and a flag that says whether rendering is on. All inputs are synchronous to the CPU clock.

On each counted line the counter may first take an extra step down on line 0. If the counter is then zero, a request is latched, the interrupt line goes high and the counter reloads from the latch. In every case the counter then steps down once more, on the reloading line too. While a request is pending, counting stops. The interrupt line stays high until the disable register is written.

Top module: `scanline_irq`

## Requirements
- R1: After reset the interrupt output is low and the counter, latch, enable and pending request are all zero.
- R2: A write with `wr_sel`=0 loads `wr_data` into the counter and clears the pending request. A write with `wr_sel`=1 loads the reload latch and clears the pending request.
- R3: Off line 0, with the counter loaded to N and the counter set to N, the interrupt goes high on the (N+1)th counted line. On that line the counter reloads from the latch and is then decremented.
- R4: A write with `wr_sel`=2 clears enable and the pending request and drives the interrupt output low in the next cycle.
- R5: While a request is pending, line pulses leave the counter unchanged. A write with `wr_sel`=3 sets enable and clears the pending request, and counting then resumes from the held value.
- R6: With enable clear, line pulses never count and never raise the interrupt.
- R7: On line 0 a nonzero counter is decremented once before the zero check, so a counter of 2 fires on the second counted line when the first of those lines is line 0.
- R8: Pulses count only when the line number is at most `LAST_LINE` (default 239) and `render_on` is high. Other pulses leave the state unchanged.
- R9: Once high, the interrupt output stays high through pulses and through writes with `wr_sel` 0, 1 or 3. Only a `wr_sel`=2 write lowers it.
- R10: The counter wraps modulo 2^CW when decremented. With the latch at 0, a reload leaves 255 in the counter, and the next interrupt comes on the 256th counted line.
- R11: When a write and a line pulse fall in the same cycle, the write takes effect and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 counter, 1 latch, 2 disable, 3 enable |
| wr_data | input | CW | Write data |
| line_pulse | input | 1 | One-cycle pulse per video line |
| line_num | input | LW | Current line number |
| render_on | input | 1 | Rendering enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the wrap after a reload from a zero latch. Reaching it takes a fire on the first counted line, an acknowledge, and then a run of 255 silent lines before the 256th fires. The bench gets there by driving long runs of pulses on a mid-frame line, and it checks the interrupt on both sides of the boundary. The extra step on line 0 is separated from ordinary counting by comparing runs that start on line 0 with runs that start elsewhere.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int CW = 8,
  parameter int LW = 9,
  parameter int LAST_LINE = 239
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          line_pulse,
  input  logic [LW-1:0] line_num,
  input  logic          render_on,
  output logic          irq
);
  localparam logic [1:0] SEL_CNT = 2'd0;
  localparam logic [1:0] SEL_LAT = 2'd1;
  localparam logic [1:0] SEL_OFF = 2'd2;
  localparam logic [1:0] SEL_ON  = 2'd3;
  localparam logic [LW-1:0] LAST = LW'(LAST_LINE);

  logic [CW-1:0] cnt, latch;
  logic          enable, pend;
  logic          counted, hit;
  logic [CW-1:0] cnt_pre, cnt_base;

  assign counted  = line_pulse && !wr_en && render_on && (line_num <= LAST) && enable && !pend;
  assign cnt_pre  = ((line_num == '0) && (cnt != '0)) ? cnt - 1'b1 : cnt;
  assign hit      = (cnt_pre == '0);
  assign cnt_base = hit ? latch : cnt_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      latch  <= '0;
      enable <= 1'b0;
      pend   <= 1'b0;
      irq    <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CNT: begin cnt <= wr_data; pend <= 1'b0; end
        SEL_LAT: begin latch <= wr_data; pend <= 1'b0; end
        SEL_OFF: begin enable <= 1'b0; pend <= 1'b0; irq <= 1'b0; end
        SEL_ON:  begin enable <= 1'b1; pend <= 1'b0; end
        default: ;
      endcase
    end else if (counted) begin
      cnt <= cnt_base - 1'b1;
      if (hit) begin
        pend <= 1'b1;
        irq  <= 1'b1;
      end
    end
  end
endmodule

module scanline_irq_chk #(
  parameter int CW = 8,
  parameter int LW = 9,
  parameter int LAST_LINE = 239
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [CW-1:0] wr_data,
  input logic          line_pulse,
  input logic [LW-1:0] line_num,
  input logic          render_on,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic          pend,
  input logic          enable
);
  AST_OFF_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 |=> !irq && !pend && !enable); // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(wr_en && wr_sel == 2'd2) |=> irq); // R9
  AST_FREEZE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !wr_en |=> $stable(cnt) && pend); // R5
  AST_GATE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && (!render_on || line_num > LW'(LAST_LINE)) |=> $stable(cnt) && $stable(pend)); // R8
  AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !wr_en |=> $stable(cnt) && !$rose(irq)); // R6
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd0 |=> cnt == $past(wr_data) && !pend); // R2
  AST_RISE_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> pend); // R3
endmodule

bind scanline_irq scanline_irq_chk #(.CW(CW), .LW(LW), .LAST_LINE(LAST_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .line_pulse(line_pulse), .line_num(line_num), .render_on(render_on), .irq(irq),
  .cnt(cnt), .pend(pend), .enable(enable));

// File: tb/scanline_irq_test.sv
module scanline_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       line_pulse = 1'b0;
  logic [8:0] line_num = 9'd0;
  logic       render_on = 1'b1;
  logic       irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scanline_irq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .line_pulse(line_pulse), .line_num(line_num), .render_on(render_on), .irq(irq));

  task automatic check(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int ln, logic ren);
    line_pulse = 1'b1; line_num = 9'(ln); render_on = ren;
    @(negedge clk);
    line_pulse = 1'b0; render_on = 1'b1;
  endtask

  task automatic pulses(int n, int ln);
    for (int i = 0; i < n; i++) pulse(ln, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 reset irq low", irq, 1'b0);
  endtask

  task automatic t_disabled();
    pulses(3, 5);
    check("R6 disabled no irq", irq, 1'b0);
  endtask

  task automatic t_basic();
    wr(2'd1, 8'd5); wr(2'd0, 8'd3); wr(2'd3, 8'd0);
    pulses(3, 10);
    check("R3 quiet before N+1", irq, 1'b0);
    pulse(10, 1'b1);
    check("R3 fires on N+1 (R2 load)", irq, 1'b1);
  endtask

  task automatic t_freeze();
    pulses(10, 20);
    check("R9 held while pending", irq, 1'b1);
    wr(2'd2, 8'd0);
    check("R4 disable lowers irq", irq, 1'b0);
    wr(2'd3, 8'd0);
    pulses(4, 20);
    check("R5 counter frozen at 4", irq, 1'b0);
    pulse(20, 1'b1);
    check("R5 resumes and fires", irq, 1'b1);
  endtask

  task automatic t_line0();
    wr(2'd2, 8'd0); wr(2'd0, 8'd2); wr(2'd3, 8'd0);
    pulse(0, 1'b1);
    check("R7 line0 first pulse quiet", irq, 1'b0);
    pulse(1, 1'b1);
    check("R7 line0 extra step fires", irq, 1'b1);
  endtask

  task automatic t_gate();
    wr(2'd2, 8'd0); wr(2'd0, 8'd1); wr(2'd3, 8'd0);
    for (int i = 0; i < 3; i++) pulse(30, 1'b0);
    pulse(240, 1'b1); pulse(261, 1'b1);
    pulse(30, 1'b1);
    check("R8 gated pulses ignored", irq, 1'b0);
    pulse(30, 1'b1);
    check("R8 counting after gating", irq, 1'b1);
  endtask

  task automatic t_sticky();
    wr(2'd1, 8'd7);
    check("R9 latch write keeps irq", irq, 1'b1);
    wr(2'd0, 8'd9);
    check("R9 counter write keeps irq", irq, 1'b1);
    wr(2'd3, 8'd0);
    pulses(2, 40);
    check("R9 enable write keeps irq", irq, 1'b1);
  endtask

  task automatic t_wrap();
    wr(2'd2, 8'd0); wr(2'd1, 8'd0); wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    pulse(100, 1'b1);
    check("R10 zero counter fires", irq, 1'b1);
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    pulses(255, 100);
    check("R10 quiet after 255", irq, 1'b0);
    pulse(100, 1'b1);
    check("R10 wrap fires at 256", irq, 1'b1);
  endtask

  task automatic t_collide();
    wr(2'd2, 8'd0); wr(2'd1, 8'd4); wr(2'd0, 8'd1); wr(2'd3, 8'd0);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'd4;
    line_pulse = 1'b1; line_num = 9'd50;
    @(negedge clk);
    wr_en = 1'b0; line_pulse = 1'b0;
    pulse(50, 1'b1);
    check("R11 colliding pulse dropped", irq, 1'b0);
    pulse(50, 1'b1);
    check("R11 fires one later", irq, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_disabled(); t_basic(); t_freeze(); t_line0();
    t_gate(); t_sticky(); t_wrap(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule